// File: doc/BRIEF.md
# Multi-Source Configurable I/O Port Bank

This block is a bank of four general-purpose I/O ports with 27 pins in all. Three ports are eight pins wide and the fourth is three pins wide. Each pin has its own output multiplexer, which picks one of four drivers:

- a bit that the host writes into a data-out register;
- a bit of a bus address, captured by a level-sensitive latch under an address-latch strobe;
- a macrocell output from neighbouring programmable logic;
- one of two external chip-select lines.

A pin drives when its direction bit is set or when an external product-term enable asks it to. At all other times its output enable is low, and the pin can be read as an input.

The host reaches the bank over a small register bus. It writes the data-out, direction and source-select registers. It reads back one source at a time: the synchronised pin levels, the data-out register, the direction register, the select bits, or the macrocell outputs. On the two lower ports the host writes the source select for each pin. On the two upper ports the select comes from static configuration inputs, and host writes to those selects are dropped.

Top module: `mio_port_bank`

## Requirements
- R1: Reset clears the data-out, direction and host select registers and the address latch. While product-term enables are low, every pin then has output enable 0 and drives its data-out bit (0).
- R2: Writing offset 1 of a port loads that port's data-out register at the next clock edge. Pin k of a port has flat index 8*port+k. The registers of other ports do not change.
- R3: A pin's output enable is the OR of its direction bit (offset 2) and its product-term enable input. Pins with neither set have output enable 0.
- R4: Each pin uses a 2-bit select. The codes are 0 = data-out bit, 1 = latched address bit k (k is the pin index within its port), 2 = macrocell output, 3 = chip-select line xcs[k mod 2].
- R5: On ports 0 and 1 the host writes the selects. Offset 3 holds pins 0-3 and offset 5 holds pins 4-7, with pin k at bits 2*(k mod 4)+1 : 2*(k mod 4). On ports 2 and 3 writes to those offsets are ignored. Their selects come from cfg_sel: port 2 uses bits 15:0 and port 3 uses bits 21:16, with pin k at bits 2k+1 : 2k. The select offsets read back the select in force.
- R6: The address latch follows bus_addr while ale is high and holds its last value while ale is low.
- R7: The data-in readback (offset 0) returns pin_in delayed by two clock edges, through a two-flop synchroniser.
- R8: The register address is reg_addr[4:3] for the port and reg_addr[2:0] for the offset. Offset 4 reads the raw macrocell outputs. Offsets 6 and 7 read 0. Bits above a port's width read 0.
- R9: The read data is combinational on reg_addr and the sources, and needs no clock edge.
- R10: Data-out, direction and select registers keep their values when no write strobe is addressed to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | 5 | Register address (port, offset) |
| reg_wdata | input | 8 | Register write data |
| reg_wr | input | 1 | Register write strobe |
| reg_rdata | output | 8 | Register read data |
| bus_addr | input | 8 | Address bus to be latched |
| ale | input | 1 | Address-latch enable, transparent when high |
| mcell_out | input | 27 | Macrocell outputs, one per pin |
| xcs | input | 2 | External chip-select lines |
| pterm_oe | input | 27 | Product-term output enables, one per pin |
| cfg_sel | input | 22 | Static source selects for ports 2 and 3 |
| pin_in | input | 27 | Pin input levels |
| pin_out | output | 27 | Pin output values |
| pin_oe | output | 27 | Pin output enables |

## Verification
The bench sets a different source on each pin of one port. It then toggles only one source at a time, so a wrong select decode shows up as the wrong pin moving, and a chip-select lane chosen from the wrong index would follow the other chip-select line. It writes select data to the static ports and expects no change. A design that let those writes through would switch the pins to data-out. The bench drops ale and then moves bus_addr, so a latch wired as a plain wire shows the new address. It samples the data-in readback one edge and two edges after a pin change, which catches a synchroniser that is one flop short or one flop long. It also reads the unmapped offsets and the upper bits of the narrow port, which must read 0.

// File: rtl/mio_pkg.sv
package mio_pkg;
  localparam int DW  = 8;
  localparam int NCS = 2;

  localparam logic [2:0] OFF_DIN   = 3'd0;
  localparam logic [2:0] OFF_DOUT  = 3'd1;
  localparam logic [2:0] OFF_DIR   = 3'd2;
  localparam logic [2:0] OFF_SELLO = 3'd3;
  localparam logic [2:0] OFF_MCELL = 3'd4;
  localparam logic [2:0] OFF_SELHI = 3'd5;

  typedef enum logic [1:0] {
    SRC_DOUT  = 2'd0,
    SRC_ADDR  = 2'd1,
    SRC_MCELL = 2'd2,
    SRC_XCS   = 2'd3
  } src_e;

  function automatic logic pick_src(input logic [1:0] sel, input logic d,
                                    input logic a, input logic m, input logic c);
    logic r;
    case (src_e'(sel))
      SRC_DOUT:  r = d;
      SRC_ADDR:  r = a;
      SRC_MCELL: r = m;
      default:   r = c;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/mio_addr_latch.sv
module mio_addr_latch #(
  parameter int AW = 8
) (
  input  logic          rst_n,
  input  logic          clk,
  input  logic          ale,
  input  logic [AW-1:0] bus_addr,
  output logic [AW-1:0] addr_q
);
  always_latch begin
    if (!rst_n)   addr_q <= '0;
    else if (ale) addr_q <= bus_addr;
  end

  AST_LATCH_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> addr_q == bus_addr); // R6
  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale && !$past(ale)) |-> $stable(addr_q)); // R6
endmodule

// File: rtl/mio_sync2.sv
module mio_sync2 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] s1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      q  <= '0;
    end else begin
      s1 <= d;
      q  <= s1;
    end
  end
endmodule

// File: rtl/mio_port.sv
module mio_port import mio_pkg::*; #(
  parameter int W        = 8,
  parameter bit HOST_SEL = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_dout,
  input  logic           wr_dir,
  input  logic           wr_sello,
  input  logic           wr_selhi,
  input  logic [DW-1:0]  wdata,
  input  logic [W-1:0]   addr_bits,
  input  logic [W-1:0]   mcell,
  input  logic [NCS-1:0] xcs,
  input  logic [W-1:0]   pterm_oe,
  input  logic [2*W-1:0] static_sel,
  input  logic [W-1:0]   pin_in,
  output logic [W-1:0]   pin_out,
  output logic [W-1:0]   pin_oe,
  output logic [W-1:0]   rd_din,
  output logic [W-1:0]   rd_dout,
  output logic [W-1:0]   rd_dir,
  output logic [2*W-1:0] rd_sel
);
  localparam int SW = 2 * W;

  logic [W-1:0]  dout_q, dir_q;
  logic [SW-1:0] sel_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '0;
    end else begin
      if (wr_dout) dout_q <= wdata[W-1:0];
      if (wr_dir)  dir_q  <= wdata[W-1:0];
    end
  end

  generate
    if (W < DW) begin : g_narrow
      logic unused_wdata_hi;
      assign unused_wdata_hi = ^wdata[DW-1:W];
    end

    if (HOST_SEL) begin : g_host
      logic [SW-1:0] sel_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= '0;
        else begin
          for (int b = 0; b < SW; b++) begin
            if (b < DW) begin
              if (wr_sello) sel_q[b] <= wdata[b % DW];
            end else if (wr_selhi) begin
              sel_q[b] <= wdata[b % DW];
            end
          end
        end
      end
      assign sel_eff = sel_q;
      logic unused_static;
      assign unused_static = ^static_sel;

      AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_sello && !wr_selhi) |=> $stable(sel_q)); // R10
    end else begin : g_static
      assign sel_eff = static_sel;
      logic unused_selwr;
      assign unused_selwr = wr_sello ^ wr_selhi;
    end
  endgenerate

  mio_sync2 #(.W(W)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pin_in),
    .q    (rd_din)
  );

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_pin
      assign pin_out[i] = pick_src(sel_eff[2*i +: 2], dout_q[i], addr_bits[i],
                                   mcell[i], xcs[i % NCS]);
      assign pin_oe[i]  = dir_q[i] | pterm_oe[i];

      AST_QUIET_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_q[i] && !pterm_oe[i]) |-> !pin_oe[i]); // R3
    end
  endgenerate

  assign rd_dout = dout_q;
  assign rd_dir  = dir_q;
  assign rd_sel  = sel_eff;

  // synchroniser warm-up counter for the latency check
  logic [1:0] warm_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             warm_cnt <= '0;
    else if (warm_cnt != 2) warm_cnt <= warm_cnt + 2'd1;
  end
  wire sync_warm = (warm_cnt == 2'd2);

  AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dout |=> $stable(dout_q)); // R10
  AST_SYNC_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    sync_warm |-> rd_din == $past(pin_in, 2)); // R7
endmodule

// File: rtl/mio_port_bank.sv
module mio_port_bank import mio_pkg::*; #(
  parameter int WIDE_W   = 8,
  parameter int NARROW_W = 3,
  parameter int ADDR_W   = 8,
  localparam int NPORT   = 4,
  localparam int NPINS   = 3 * WIDE_W + NARROW_W,
  localparam int CFG_W   = 2 * (WIDE_W + NARROW_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  input  logic             reg_wr,
  output logic [DW-1:0]    reg_rdata,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic             ale,
  input  logic [NPINS-1:0] mcell_out,
  input  logic [NCS-1:0]   xcs,
  input  logic [NPINS-1:0] pterm_oe,
  input  logic [CFG_W-1:0] cfg_sel,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe
);
  logic [ADDR_W-1:0] addr_q;
  logic [1:0] pidx;
  logic [2:0] off;
  assign pidx = reg_addr[4:3];
  assign off  = reg_addr[2:0];

  logic [DW-1:0] rd_din_a [NPORT];
  logic [DW-1:0] rd_dout_a[NPORT];
  logic [DW-1:0] rd_dir_a [NPORT];
  logic [DW-1:0] rd_sello_a[NPORT];
  logic [DW-1:0] rd_selhi_a[NPORT];
  logic [DW-1:0] rd_mc_a  [NPORT];

  mio_addr_latch #(.AW(ADDR_W)) u_alatch (
    .rst_n   (rst_n),
    .clk     (clk),
    .ale     (ale),
    .bus_addr(bus_addr),
    .addr_q  (addr_q)
  );

  genvar p;
  generate
    for (p = 0; p < NPORT; p++) begin : g_port
      localparam int W    = (p < 3) ? WIDE_W : NARROW_W;
      localparam int BASE = p * WIDE_W;
      localparam bit HOST = (p < 2);

      logic [W-1:0]   din, dout, dir;
      logic [2*W-1:0] sel, stat;
      wire sel_hit = reg_wr && (pidx == p[1:0]);

      if (HOST) begin : g_nocfg
        assign stat = '0;
      end else begin : g_cfg
        assign stat = cfg_sel[(p-2)*2*WIDE_W +: 2*W];
      end

      mio_port #(.W(W), .HOST_SEL(HOST)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_dout   (sel_hit && off == OFF_DOUT),
        .wr_dir    (sel_hit && off == OFF_DIR),
        .wr_sello  (sel_hit && off == OFF_SELLO),
        .wr_selhi  (sel_hit && off == OFF_SELHI),
        .wdata     (reg_wdata),
        .addr_bits (addr_q[W-1:0]),
        .mcell     (mcell_out[BASE +: W]),
        .xcs       (xcs),
        .pterm_oe  (pterm_oe[BASE +: W]),
        .static_sel(stat),
        .pin_in    (pin_in[BASE +: W]),
        .pin_out   (pin_out[BASE +: W]),
        .pin_oe    (pin_oe[BASE +: W]),
        .rd_din    (din),
        .rd_dout   (dout),
        .rd_dir    (dir),
        .rd_sel    (sel)
      );

      assign rd_din_a[p]   = DW'(din);
      assign rd_dout_a[p]  = DW'(dout);
      assign rd_dir_a[p]   = DW'(dir);
      assign rd_mc_a[p]    = DW'(mcell_out[BASE +: W]);
      assign rd_sello_a[p] = DW'(sel);
      if (2 * W > DW) begin : g_hi
        assign rd_selhi_a[p] = DW'(sel[2*W-1:DW]);
      end else begin : g_nohi
        assign rd_selhi_a[p] = '0;
      end
    end
  endgenerate

  if (ADDR_W > WIDE_W) begin : g_addr_spare
    logic unused_addr;
    assign unused_addr = ^addr_q[ADDR_W-1:WIDE_W];
  end

  always_comb begin
    case (off)
      OFF_DIN:   reg_rdata = rd_din_a[pidx];
      OFF_DOUT:  reg_rdata = rd_dout_a[pidx];
      OFF_DIR:   reg_rdata = rd_dir_a[pidx];
      OFF_SELLO: reg_rdata = rd_sello_a[pidx];
      OFF_MCELL: reg_rdata = rd_mc_a[pidx];
      OFF_SELHI: reg_rdata = rd_selhi_a[pidx];
      default:   reg_rdata = '0;
    endcase
  end

  AST_RD_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (off > OFF_SELHI) |-> reg_rdata == '0); // R8
  AST_NARROW_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (pidx == 2'd3 && off != OFF_SELLO && off != OFF_SELHI)
      |-> reg_rdata[DW-1:NARROW_W] == '0); // R8
endmodule

// File: tb/tb_mio_port_bank.sv
`timescale 1ns/1ps
module tb_mio_port_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_rdata;
  logic [7:0]  bus_addr = '0;
  logic        ale = 1'b0;
  logic [26:0] mcell_out = '0;
  logic [1:0]  xcs = '0;
  logic [26:0] pterm_oe = '0;
  logic [21:0] cfg_sel = '0;
  logic [26:0] pin_in = '0;
  logic [26:0] pin_out, pin_oe;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mio_port_bank dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rdata(reg_rdata), .bus_addr(bus_addr), .ale(ale),
    .mcell_out(mcell_out), .xcs(xcs), .pterm_oe(pterm_oe), .cfg_sel(cfg_sel),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  function automatic logic [4:0] ra(int p, int k);
    return {p[1:0], k[2:0]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(int p, int k, logic [7:0] d);
    @(negedge clk);
    reg_addr = ra(p, k); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(int p, int k, output logic [7:0] d);
    reg_addr = ra(p, k);
    #0.2;
    d = reg_rdata;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    for (int p = 0; p < 4; p++) begin
      rd(p, 1, d); chk("R1 dout clear", d, 0);
      rd(p, 2, d); chk("R1 dir clear", d, 0);
      rd(p, 3, d); chk("R1 sel clear", d, 0);
    end
    chk("R1 oe low", pin_oe, 0);
    chk("R1 out zero", pin_out, 0);
  endtask

  task automatic t_dout();
    logic [7:0] d;
    wr(0, 1, 8'hA5);
    wr(3, 1, 8'hFD);
    rd(0, 1, d); chk("R2 port0 dout", d, 8'hA5);
    rd(1, 1, d); chk("R2 port1 untouched", d, 8'h00);
    rd(3, 1, d); chk("R8 narrow dout upper zero", d, 8'h05);
    chk("R2 pins port0", pin_out[7:0], 8'hA5);
    chk("R2 pins port3", pin_out[26:24], 3'b101);
    chk("R2 pins port1", pin_out[15:8], 8'h00);
    @(negedge clk); @(negedge clk);
    rd(0, 1, d); chk("R10 dout held", d, 8'hA5);
  endtask

  task automatic t_dir();
    wr(1, 2, 8'h0F);
    chk("R3 dir drives oe", pin_oe[15:8], 8'h0F);
    @(negedge clk); pterm_oe[15] = 1'b1; #0.2;
    chk("R3 pterm or dir", pin_oe[15:8], 8'h8F);
    chk("R3 other ports quiet", {pin_oe[26:16], pin_oe[7:0]}, 0);
    pterm_oe = '0; #0.2;
    chk("R3 pterm released", pin_oe[15:8], 8'h0F);
  endtask

  task automatic t_latch();
    @(negedge clk); ale = 1'b1; bus_addr = 8'h5A;
    wr(0, 3, 8'h55);
    wr(0, 5, 8'h55);
    chk("R4 addr source", pin_out[7:0], 8'h5A);
    @(negedge clk); bus_addr = 8'h33; #0.2;
    chk("R6 transparent", pin_out[7:0], 8'h33);
    @(negedge clk); ale = 1'b0; #0.2;
    bus_addr = 8'hFF; #0.2;
    chk("R6 hold after fall", pin_out[7:0], 8'h33);
    @(negedge clk); @(negedge clk);
    chk("R6 hold over edges", pin_out[7:0], 8'h33);
  endtask

  task automatic t_mixed();
    logic [7:0] d;
    // pin0 macrocell, pin1 chip-select, pin2 data-out, pin3 address
    wr(1, 1, 8'h04);
    wr(1, 3, 8'h4E);
    @(negedge clk); mcell_out[8] = 1'b1; xcs = 2'b10; #0.2;
    chk("R4 mixed sources", pin_out[11:8], 4'h7);
    xcs = 2'b01; #0.2;
    chk("R4 xcs lane odd pin", pin_out[9], 1'b0);
    mcell_out[8] = 1'b0; #0.2;
    chk("R4 mcell source", pin_out[8], 1'b0);
    rd(1, 3, d); chk("R5 sel readback lo", d, 8'h4E);
    rd(1, 5, d); chk("R5 sel readback hi", d, 8'h00);
  endtask

  task automatic t_static();
    logic [7:0] d;
    @(negedge clk);
    cfg_sel[15:0] = 16'hAAAA;
    cfg_sel[21:16] = 6'b11_01_10;
    mcell_out[23:16] = 8'h96;
    mcell_out[24] = 1'b1;
    xcs = 2'b01;
    #0.2;
    chk("R5 static port2", pin_out[23:16], 8'h96);
    wr(2, 3, 8'h00);
    wr(2, 5, 8'h00);
    chk("R5 static writes ignored", pin_out[23:16], 8'h96);
    rd(2, 3, d); chk("R5 static read lo", d, 8'hAA);
    rd(2, 5, d); chk("R5 static read hi", d, 8'hAA);
    // port3: pin0 mcell(1), pin1 addr bit1 of 0x33 (1), pin2 xcs[0] (1)
    chk("R5 static port3", pin_out[26:24], 3'b111);
    @(negedge clk); xcs = 2'b00; #0.2;
    chk("R4 port3 xcs pin2", pin_out[26], 1'b0);
  endtask

  task automatic t_din();
    logic [7:0] d;
    @(negedge clk); pin_in[7:0] = 8'hC3;
    @(negedge clk);
    rd(0, 0, d); chk("R7 one edge old", d, 8'h00);
    @(negedge clk);
    rd(0, 0, d); chk("R7 two edges new", d, 8'hC3);
    pin_in[26:24] = 3'b111;
    repeat (2) @(negedge clk);
    rd(3, 0, d); chk("R8 narrow din", d, 8'h07);
  endtask

  task automatic t_map();
    logic [7:0] d;
    rd(1, 6, d); chk("R8 offset6 zero", d, 0);
    rd(0, 7, d); chk("R8 offset7 zero", d, 0);
    rd(3, 5, d); chk("R8 narrow selhi zero", d, 0);
    mcell_out[15:8] = 8'h3C;
    rd(1, 4, d); chk("R9 mcell readback", d, 8'h3C);
    mcell_out[15:8] = 8'hC1; #0.2;
    chk("R9 comb readback", reg_rdata, 8'hC1);
    rd(1, 2, d); chk("R10 dir held", d, 8'h0F);
  endtask

  task automatic t_rereset();
    logic [7:0] d;
    do_reset();
    mcell_out = '0; cfg_sel = '0;
    #0.2;
    rd(0, 1, d); chk("R1 dout after rereset", d, 0);
    rd(0, 3, d); chk("R1 sel after rereset", d, 0);
    rd(1, 2, d); chk("R1 dir after rereset", d, 0);
    chk("R1 pins idle", pin_oe, 0);
    @(negedge clk); ale = 1'b0; #0.2;
    wr(0, 3, 8'h55); wr(0, 5, 8'h55);
    chk("R1 latch cleared", pin_out[7:0], 8'h00);
  endtask

  initial begin
    do_reset();
    t_reset();
    t_dout();
    t_dir();
    t_latch();
    t_mixed();
    t_static();
    t_din();
    t_map();
    t_rereset();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule